// File: doc/BRIEF.md
# Shared Buffer Pool Allocator

This block keeps the buffer accounting for a group of ports that draw packet buffers from one shared memory, typically the ports that together make up a sixteen-lane group. It holds no data and moves no packets. It only decides, on every clock, whether a port's request for one more buffer is granted. It also tracks how many buffers each port holds.

Each port has a guaranteed floor of buffers. The floors are programmable, and whatever the floors leave of the total is a common pool. A request is served from the port's own floor first. Once the floor is used up, the port may borrow from the pool, but only if its floor usage stands above a programmable threshold. By default the threshold is a quarter of the floor. Pool buffers go to at most one port per cycle, in rotating order. A freed buffer is charged against the port's borrowed count before its own count, so borrowed buffers return to the pool. Floors and thresholds can be rewritten only while no buffer is held anywhere. A floor set whose sum exceeds the total raises an error flag, and no request is granted while the flag is up.

Top module: `sbp_alloc`

## Requirements
- R1: After reset, every port's floor is `DEF_MIN` (8) and its threshold is `DEF_THR` (2, a quarter of the floor). No grant is given without a request, and `cfg_err` is low.
- R2: A requesting port whose own-use count is below its floor is granted in the same cycle, whatever the pool level and whatever the other ports do, and its own-use count rises by one.
- R3: A requesting port whose own-use count equals its floor is granted one pool buffer if all of these hold: its own-use count is strictly above its threshold, the pool holds at least one buffer, and the port wins the rotation.
- R4: A request is refused when the port's floor is full and either the pool is empty or its own-use count is not above its threshold. In particular, a threshold equal to the floor disables borrowing.
- R5: At most one pool buffer is granted per cycle. Pool candidates are scanned starting from the port after the last pool winner, wrapping round, beginning at port 0 after reset.
- R6: A free strobe lowers the port's borrowed count if it is nonzero, otherwise its own-use count, and a free with both counts at zero has no effect. A borrowed buffer that is freed can be granted to any port from the next cycle on.
- R7: A configuration write (`cfg_we` with `cfg_sel`, `cfg_min`, `cfg_thr`) takes effect at the clock edge only if every own-use and borrowed count is zero on that cycle. Otherwise the write is dropped.
- R8: `cfg_err` is high whenever the sum of the floors exceeds `TOTAL_BUFS` (64). While it is high every request is refused.
- R9: The pool level is always `TOTAL_BUFS` minus the sum of the floors minus the sum of the borrowed counts, and it never goes below zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | NUM_PORTS | Per-port request for one buffer this cycle |
| alloc_gnt | output | NUM_PORTS | Per-port grant, same cycle as the request |
| free_stb | input | NUM_PORTS | Per-port release of one buffer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Port whose floor and threshold are written |
| cfg_min | input | CNT_W | New floor |
| cfg_thr | input | CNT_W | New borrowing threshold |
| cfg_err | output | 1 | Sum of floors exceeds the buffer total |

## Verification
The bench runs every port's floor to full and then drives all four ports at the pool together. A broken rotation would show up here as one port taking every pool buffer, and a missing per-cycle limit as several pool grants in one clock. It drains the pool to zero and then frees borrowed buffers. A design that charged frees against the floor first would never return them to the pool, and another port's later borrow would be refused. It attempts a configuration write while buffers are held, which must be dropped. It sets a threshold equal to the floor, which must block borrowing even though the pool is non-empty. It also sets an over-committed floor set, which must block every grant. A long random phase with occasional configuration writes is compared against a behavioural model every cycle.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

   // How a port's request is served in one cycle.
   typedef enum logic [1:0] {
      TAKE_NONE = 2'd0,
      TAKE_OWN  = 2'd1,
      TAKE_POOL = 2'd2
   } take_e;

endpackage

// File: rtl/sbp_port_ctr.sv
module sbp_port_ctr
   import sbp_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  take_e            take,
   input  logic             free_stb,
   output logic [CNT_W-1:0] own_cnt,
   output logic [CNT_W-1:0] bor_cnt
);

   logic own_inc, bor_inc, own_dec, bor_dec;

   // Frees are charged to borrowed buffers before the port's own share.
   always_comb begin
      own_inc = (take == TAKE_OWN);
      bor_inc = (take == TAKE_POOL);
      bor_dec = free_stb && (bor_cnt != '0);
      own_dec = free_stb && (bor_cnt == '0) && (own_cnt != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_cnt <= '0;
         bor_cnt <= '0;
      end else begin
         own_cnt <= own_cnt + CNT_W'(own_inc) - CNT_W'(own_dec);
         bor_cnt <= bor_cnt + CNT_W'(bor_inc) - CNT_W'(bor_dec);
      end
   end

endmodule

// File: rtl/sbp_rr_pick.sv
module sbp_rr_pick #(
   parameter int N     = 4,
   parameter int SEL_W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cand,
   output logic [N-1:0] win
);

   logic [SEL_W-1:0] ptr_q;
   logic             hit;
   logic [SEL_W-1:0] hit_idx;

   always_comb begin
      win     = '0;
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = 0; i < N; i++) begin
         automatic int idx = (int'(ptr_q) + i) % N;
         if (!hit && cand[idx]) begin
            hit      = 1'b1;
            win[idx] = 1'b1;
            hit_idx  = SEL_W'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (hit) begin
         ptr_q <= (int'(hit_idx) == N - 1) ? '0 : hit_idx + 1'b1;
      end
   end

endmodule

// File: rtl/sbp_cfg_bank.sv
module sbp_cfg_bank #(
   parameter int N          = 4,
   parameter int CNT_W      = 7,
   parameter int SEL_W      = 2,
   parameter int SUM_W      = 10,
   parameter int TOTAL_BUFS = 64,
   parameter int DEF_MIN    = 8,
   parameter int DEF_THR    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [CNT_W-1:0] cfg_min,
   input  logic [CNT_W-1:0] cfg_thr,
   output logic [CNT_W-1:0] min_q [N],
   output logic [CNT_W-1:0] thr_q [N],
   output logic [SUM_W-1:0] sum_min,
   output logic             over_commit
);

   logic wr_ok;

   assign wr_ok = cfg_we && idle && (int'(cfg_sel) < N);

   for (genvar p = 0; p < N; p++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            min_q[p] <= CNT_W'(DEF_MIN);
            thr_q[p] <= CNT_W'(DEF_THR);
         end else if (wr_ok && (int'(cfg_sel) == p)) begin
            min_q[p] <= cfg_min;
            thr_q[p] <= cfg_thr;
         end
      end
   end

   always_comb begin
      sum_min = '0;
      for (int p = 0; p < N; p++) begin
         sum_min = sum_min + SUM_W'(min_q[p]);
      end
      over_commit = (sum_min > SUM_W'(TOTAL_BUFS));
   end

endmodule

// File: rtl/sbp_alloc.sv
module sbp_alloc
   import sbp_pkg::*;
#(
   parameter int NUM_PORTS  = 4,
   parameter int TOTAL_BUFS = 64,
   parameter int DEF_MIN    = TOTAL_BUFS / (2 * NUM_PORTS),
   parameter int DEF_THR    = DEF_MIN / 4,
   parameter int CNT_W      = $clog2(TOTAL_BUFS + 1),
   parameter int SEL_W      = $clog2(NUM_PORTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] alloc_req,
   output logic [NUM_PORTS-1:0] alloc_gnt,
   input  logic [NUM_PORTS-1:0] free_stb,
   input  logic                 cfg_we,
   input  logic [SEL_W-1:0]     cfg_sel,
   input  logic [CNT_W-1:0]     cfg_min,
   input  logic [CNT_W-1:0]     cfg_thr,
   output logic                 cfg_err
);

   localparam int SUM_W = CNT_W + $clog2(NUM_PORTS) + 1;

   // Elaboration-time parameter checks.
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("sbp_alloc: NUM_PORTS must be at least 2");
   end
   if (CNT_W < $clog2(TOTAL_BUFS + 1)) begin : g_bad_cnt
      $error("sbp_alloc: CNT_W too narrow for TOTAL_BUFS");
   end
   if (SEL_W < $clog2(NUM_PORTS)) begin : g_bad_sel
      $error("sbp_alloc: SEL_W too narrow for NUM_PORTS");
   end
   if (DEF_MIN * NUM_PORTS > TOTAL_BUFS || DEF_THR > DEF_MIN) begin : g_bad_def
      $error("sbp_alloc: default floors or thresholds inconsistent");
   end

   logic [CNT_W-1:0]           own_cnt [NUM_PORTS];
   logic [CNT_W-1:0]           bor_cnt [NUM_PORTS];
   logic [CNT_W-1:0]           min_q   [NUM_PORTS];
   logic [CNT_W-1:0]           thr_q   [NUM_PORTS];
   logic [SUM_W-1:0]           sum_min;
   logic [SUM_W-1:0]           sum_bor;
   logic                       over_commit;
   logic                       idle;
   logic                       pool_nz;
   logic [NUM_PORTS-1:0]       own_ok;
   logic [NUM_PORTS-1:0]       pool_cand;
   logic [NUM_PORTS-1:0]       pool_win;
   logic [NUM_PORTS*CNT_W-1:0] own_flat, bor_flat, min_flat, thr_flat;

   sbp_cfg_bank #(
      .N          (NUM_PORTS),
      .CNT_W      (CNT_W),
      .SEL_W      (SEL_W),
      .SUM_W      (SUM_W),
      .TOTAL_BUFS (TOTAL_BUFS),
      .DEF_MIN    (DEF_MIN),
      .DEF_THR    (DEF_THR)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle        (idle),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_min     (cfg_min),
      .cfg_thr     (cfg_thr),
      .min_q       (min_q),
      .thr_q       (thr_q),
      .sum_min     (sum_min),
      .over_commit (over_commit)
   );

   always_comb begin
      sum_bor = '0;
      idle    = 1'b1;
      for (int p = 0; p < NUM_PORTS; p++) begin
         sum_bor = sum_bor + SUM_W'(bor_cnt[p]);
         if (own_cnt[p] != '0 || bor_cnt[p] != '0) begin
            idle = 1'b0;
         end
      end
      pool_nz = (sum_min + sum_bor) < SUM_W'(TOTAL_BUFS);
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      take_e take;

      assign own_ok[p]    = alloc_req[p] && !over_commit && (own_cnt[p] < min_q[p]);
      assign pool_cand[p] = alloc_req[p] && !over_commit && pool_nz &&
                            (own_cnt[p] >= min_q[p]) && (own_cnt[p] > thr_q[p]);
      assign take         = own_ok[p]   ? TAKE_OWN  :
                            pool_win[p] ? TAKE_POOL : TAKE_NONE;

      sbp_port_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .take     (take),
         .free_stb (free_stb[p]),
         .own_cnt  (own_cnt[p]),
         .bor_cnt  (bor_cnt[p])
      );

      assign own_flat[p*CNT_W +: CNT_W] = own_cnt[p];
      assign bor_flat[p*CNT_W +: CNT_W] = bor_cnt[p];
      assign min_flat[p*CNT_W +: CNT_W] = min_q[p];
      assign thr_flat[p*CNT_W +: CNT_W] = thr_q[p];
   end

   sbp_rr_pick #(.N(NUM_PORTS), .SEL_W(SEL_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (pool_cand),
      .win   (pool_win)
   );

   assign alloc_gnt = own_ok | pool_win;
   assign cfg_err   = over_commit;

endmodule

// File: rtl/sbp_alloc_chk.sv
module sbp_alloc_chk #(
   parameter int NUM_PORTS  = 4,
   parameter int TOTAL_BUFS = 64,
   parameter int CNT_W      = 7,
   parameter int SUM_W      = 10
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_PORTS-1:0]       alloc_req,
   input logic [NUM_PORTS-1:0]       alloc_gnt,
   input logic [NUM_PORTS-1:0]       pool_win,
   input logic                       cfg_we,
   input logic                       cfg_err,
   input logic                       idle,
   input logic [SUM_W-1:0]           sum_min,
   input logic [SUM_W-1:0]           sum_bor,
   input logic [NUM_PORTS*CNT_W-1:0] own_flat,
   input logic [NUM_PORTS*CNT_W-1:0] min_flat,
   input logic [NUM_PORTS*CNT_W-1:0] thr_flat
);

   assert_gnt_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_gnt & ~alloc_req) == '0);

   assert_one_pool_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pool_win));

   assert_err_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (alloc_gnt == '0));

   assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !idle) |=> ($stable(min_flat) && $stable(thr_flat)));

   assert_no_overdraw_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_err |-> ((sum_min + sum_bor) <= SUM_W'(TOTAL_BUFS)));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      assert_borrow_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
         pool_win[p] |-> (own_flat[p*CNT_W +: CNT_W] == min_flat[p*CNT_W +: CNT_W] &&
                          own_flat[p*CNT_W +: CNT_W] >  thr_flat[p*CNT_W +: CNT_W]));
   end

endmodule

bind sbp_alloc sbp_alloc_chk #(
   .NUM_PORTS  (NUM_PORTS),
   .TOTAL_BUFS (TOTAL_BUFS),
   .CNT_W      (CNT_W),
   .SUM_W      (SUM_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .alloc_req (alloc_req),
   .alloc_gnt (alloc_gnt),
   .pool_win  (pool_win),
   .cfg_we    (cfg_we),
   .cfg_err   (cfg_err),
   .idle      (idle),
   .sum_min   (sum_min),
   .sum_bor   (sum_bor),
   .own_flat  (own_flat),
   .min_flat  (min_flat),
   .thr_flat  (thr_flat)
);

// File: tb/sbp_alloc_bench.sv
module sbp_alloc_bench;

   localparam int N     = 4;
   localparam int TOTAL = 64;
   localparam int CNT_W = 7;
   localparam int SEL_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N-1:0]     alloc_req = '0;
   logic [N-1:0]     alloc_gnt;
   logic [N-1:0]     free_stb = '0;
   logic             cfg_we = 1'b0;
   logic [SEL_W-1:0] cfg_sel = '0;
   logic [CNT_W-1:0] cfg_min = '0;
   logic [CNT_W-1:0] cfg_thr = '0;
   logic             cfg_err;

   always #10 clk = ~clk;   // 50 MHz

   sbp_alloc #(.NUM_PORTS(N), .TOTAL_BUFS(TOTAL)) u_sbp_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_req (alloc_req),
      .alloc_gnt (alloc_gnt),
      .free_stb  (free_stb),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_min   (cfg_min),
      .cfg_thr   (cfg_thr),
      .cfg_err   (cfg_err)
   );

   // Behavioural reference state.
   int    m_min [N];
   int    m_thr [N];
   int    m_own [N];
   int    m_bor [N];
   int    m_rr;
   int    compared = 0;
   int    mismatched = 0;
   bit    done = 1'b0;
   string phase = "R1";

   logic [N-1:0] e_gnt;
   logic         e_err;
   int           e_win;

   task automatic model_eval();
      int sm, sb;
      sm = 0; sb = 0;
      for (int p = 0; p < N; p++) begin
         sm += m_min[p];
         sb += m_bor[p];
      end
      e_err = (sm > TOTAL);
      e_gnt = '0;
      e_win = -1;
      if (!e_err) begin
         for (int p = 0; p < N; p++)
            if (alloc_req[p] && m_own[p] < m_min[p]) e_gnt[p] = 1'b1;
         if (sm + sb < TOTAL) begin
            for (int i = 0; i < N; i++) begin
               automatic int q = (m_rr + i) % N;
               if (e_win < 0 && alloc_req[q] && m_own[q] >= m_min[q] && m_own[q] > m_thr[q])
                  e_win = q;
            end
         end
         if (e_win >= 0) e_gnt[e_win] = 1'b1;
      end
   endtask

   task automatic model_update();
      bit idle = 1'b1;
      for (int p = 0; p < N; p++)
         if (m_own[p] != 0 || m_bor[p] != 0) idle = 1'b0;
      for (int p = 0; p < N; p++) begin
         automatic bit fb = free_stb[p] && m_bor[p] > 0;
         automatic bit fo = free_stb[p] && m_bor[p] == 0 && m_own[p] > 0;
         if (fb) m_bor[p]--;
         if (fo) m_own[p]--;
         if (e_gnt[p]) begin
            if (p == e_win) m_bor[p]++;
            else            m_own[p]++;
         end
      end
      if (e_win >= 0) m_rr = (e_win + 1) % N;
      if (cfg_we && idle && int'(cfg_sel) < N) begin
         m_min[cfg_sel] = int'(cfg_min);
         m_thr[cfg_sel] = int'(cfg_thr);
      end
   endtask

   // Inputs are set at a falling edge; compare mid-low phase; update at rise.
   task automatic tick();
      #5;
      model_eval();
      compared++;
      if (alloc_gnt !== e_gnt || cfg_err !== e_err) begin
         mismatched++;
         $display("FAIL %s t=%0t gnt=%b err=%b expected gnt=%b err=%b",
                  phase, $time, alloc_gnt, cfg_err, e_gnt, e_err);
      end
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic run(input logic [N-1:0] req, input logic [N-1:0] fre, input int n);
      alloc_req = req;
      free_stb  = fre;
      for (int i = 0; i < n; i++) tick();
      alloc_req = '0;
      free_stb  = '0;
   endtask

   task automatic cfg(input int sel, input int mn, input int th);
      cfg_we  = 1'b1;
      cfg_sel = SEL_W'(sel);
      cfg_min = CNT_W'(mn);
      cfg_thr = CNT_W'(th);
      tick();
      cfg_we  = 1'b0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      for (int p = 0; p < N; p++) begin
         m_min[p] = 8; m_thr[p] = 2; m_own[p] = 0; m_bor[p] = 0;
      end
      m_rr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      phase = "R1"; run(4'b0000, 4'b0000, 3);           // reset state
      phase = "R2"; run(4'b0001, 4'b0000, 8);           // port 0 floor fills
      phase = "R3"; run(4'b0001, 4'b0000, 4);           // port 0 borrows 4
      phase = "R2"; run(4'b1110, 4'b0000, 8);           // other floors fill together
      phase = "R5"; run(4'b1111, 4'b0000, 12);          // rotation, one per cycle
      phase = "R4"; run(4'b1111, 4'b0000, 20);          // pool runs dry, refusals
      phase = "R7"; cfg(1, 0, 0);                       // busy: dropped
      phase = "R6"; run(4'b0000, 4'b0001, 2);           // port 0 returns borrowed
      phase = "R6"; run(4'b0010, 4'b0000, 3);           // port 1 can borrow them
      phase = "R6"; run(4'b0000, 4'b1111, 40);          // drain
      phase = "R6"; run(4'b0000, 4'b1111, 3);           // frees at zero ignored
      phase = "R7"; cfg(0, 4, 4);                       // idle: accepted
      phase = "R4"; run(4'b0001, 4'b0000, 6);           // threshold==floor blocks borrowing
      phase = "R6"; run(4'b0000, 4'b1111, 10);
      phase = "R8"; cfg(1, 60, 15);                     // over-committed
      phase = "R8"; run(4'b1111, 4'b0000, 4);
      phase = "R8"; cfg(1, 8, 2);
      phase = "R1"; run(4'b0000, 4'b0000, 2);

      phase = "R9";
      for (int i = 0; i < 1500; i++) begin
         alloc_req = N'($urandom);
         free_stb  = N'($urandom) & N'($urandom);
         cfg_we    = ($urandom % 16) == 0;
         cfg_sel   = SEL_W'($urandom);
         cfg_min   = CNT_W'($urandom % 20);
         cfg_thr   = CNT_W'($urandom % 20);
         tick();
         if (i % 200 == 199) begin
            cfg_we = 1'b0;
            run(4'b0000, 4'b1111, 70);
         end
      end
      cfg_we = 1'b0;
      run(4'b0000, 4'b0000, 2);
      finish_up();
   end

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired in phase %s", phase);
      finish_up();
   end

endmodule